// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This controller decides which one of several hardware thread contexts may issue into a shared in-order pipeline. The running thread issues every cycle. It keeps the pipeline until it reports a long-latency stall of its own, such as a load that misses every cache level and has to go off chip. Nothing preempts it. When that stall is reported, the controller marks the thread as blocked. It asks the pipeline to flush that thread's younger instructions and hands the pipeline to another ready thread after a single bubble cycle.

Each context has a ready/blocked flag. A blocked context becomes eligible again only when the data it is waiting for comes back on the return port. The next thread is chosen round-robin, starting just after the thread that blocked, so no ready thread waits forever. If every context is blocked, issue stops. It resumes in the cycle after the first useful data return, with the thread whose data came back.

The controller does not check a stall from the wrong thread silently. A stall reported for a thread that is not currently issuing raises a one-cycle protocol error flag and changes nothing else.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: After reset every context is ready, the active thread ID is 0, issue-valid is 1, and both the flush request and the protocol error are 0.
- R2: While no stall is reported for the active thread, issue-valid stays 1 and the active thread ID does not change in any later cycle. No thread is ever preempted.
- R3: A stall for the active thread, sampled in cycle t, has three effects. In cycle t+1, issue-valid is 0, the flush request is 1 and the flush thread ID equals the stalled thread. In cycle t+2, the flush request is 0 again and, if a thread is ready, issue-valid is 1 with the newly selected thread.
- R4: The new thread is the first ready context in the order blocked+1, blocked+2, and so on, wrapping modulo the thread count. It is not simply the lowest-numbered ready context.
- R5: A blocked context is never selected while it is blocked. It stays blocked until a data return tagged with its ID arrives.
- R6: When no context is ready, issue-valid stays 0 from cycle t+1 onward. A data return for a blocked thread in cycle u makes that thread active with issue-valid 1 in cycle u+1.
- R7: A data return tagged with a context that is not blocked has no effect. The active thread ID, issue-valid and the flush request are unchanged.
- R8: A stall reported for a thread that is not issuing raises the protocol error output for exactly the following cycle. This covers a thread other than the active one, and any stall while issue-valid is 0. Such a stall changes neither the active thread ID nor issue-valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| miss_valid_i | input | 1 | A long-latency stall is reported this cycle |
| miss_tid_i | input | TID_W | Thread ID that caused the stall |
| ret_valid_i | input | 1 | Outstanding data has returned this cycle |
| ret_tid_i | input | TID_W | Thread ID the returned data belongs to |
| active_tid_o | output | TID_W | Thread currently owning the pipeline |
| issue_valid_o | output | 1 | The active thread may issue this cycle |
| flush_valid_o | output | 1 | Flush the stalled thread's younger instructions |
| flush_tid_o | output | TID_W | Thread whose instructions are to be flushed |
| proto_err_o | output | 1 | A stall was reported for a thread that was not issuing |

## Verification
The bench builds the block with four contexts. With four contexts the power-of-two branch of the round-robin picker is selected, and four consecutive stalls are enough to reach the state where every context is blocked and issue stops. The same default makes the modulo wrap (thread 3 handing over to thread 0) and the skip over blocked contexts easy to observe. A pick where the round-robin choice differs from the lowest ready index shows the search really starts after the stalled thread.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;

   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_SWITCH = 2'd1,
      ST_IDLE   = 2'd2
   } sched_state_e;

   function automatic int tid_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cgmt_ready_tracker.sv
module cgmt_ready_tracker #(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = 2
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   block_en_i,
   input  logic [TID_W-1:0]       block_tid_i,
   input  logic                   wake_en_i,
   input  logic [TID_W-1:0]       wake_tid_i,
   output logic [NUM_THREADS-1:0] blocked_o,
   output logic [NUM_THREADS-1:0] wake_vec_o
);

   logic [NUM_THREADS-1:0] blocked_q;

   for (genvar g = 0; g < NUM_THREADS; g++) begin : g_ctx
      logic hit_block;
      logic hit_wake;

      assign hit_block     = block_en_i && (block_tid_i == TID_W'(g));
      assign hit_wake      = wake_en_i  && (wake_tid_i  == TID_W'(g));
      assign wake_vec_o[g] = hit_wake && blocked_q[g];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            blocked_q[g] <= 1'b0;
         end else if (hit_block) begin
            blocked_q[g] <= 1'b1;
         end else if (wake_vec_o[g]) begin
            blocked_q[g] <= 1'b0;
         end
      end

      AST_WAKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (wake_vec_o[g] && !hit_block) |=> !blocked_q[g]); // R5
   end

   assign blocked_o = blocked_q;

endmodule

// File: rtl/cgmt_rr_picker.sv
module cgmt_rr_picker #(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = 2
) (
   input  logic [TID_W-1:0]       base_tid_i,
   input  logic [NUM_THREADS-1:0] cand_i,
   output logic                   found_o,
   output logic [TID_W-1:0]       pick_o
);

   localparam bit IS_POW2 = ((1 << TID_W) == NUM_THREADS);

   if (IS_POW2) begin : g_wrap_add
      always_comb begin
         found_o = 1'b0;
         pick_o  = base_tid_i;
         for (int k = 1; k <= NUM_THREADS; k++) begin
            logic [TID_W-1:0] idx;
            idx = base_tid_i + TID_W'(k);
            if (!found_o && cand_i[idx]) begin
               found_o = 1'b1;
               pick_o  = idx;
            end
         end
      end
   end else begin : g_wrap_mod
      always_comb begin
         found_o = 1'b0;
         pick_o  = base_tid_i;
         for (int k = 1; k <= NUM_THREADS; k++) begin
            int idx;
            idx = (int'(base_tid_i) + k) % NUM_THREADS;
            if (!found_o && cand_i[idx]) begin
               found_o = 1'b1;
               pick_o  = TID_W'(idx);
            end
         end
      end
   end

   always_comb begin
      if (found_o) begin
         AST_PICK_IS_CANDIDATE: assert (cand_i[pick_o]); // R4
      end
   end

endmodule

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl #(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = cgmt_pkg::tid_width(NUM_THREADS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             miss_valid_i,
   input  logic [TID_W-1:0] miss_tid_i,
   input  logic             ret_valid_i,
   input  logic [TID_W-1:0] ret_tid_i,
   output logic [TID_W-1:0] active_tid_o,
   output logic             issue_valid_o,
   output logic             flush_valid_o,
   output logic [TID_W-1:0] flush_tid_o,
   output logic             proto_err_o
);

   import cgmt_pkg::*;

   localparam int MIN_TID_W = cgmt_pkg::tid_width(NUM_THREADS);

   if (NUM_THREADS < 2) begin : g_bad_count
      $error("cgmt_switch_ctrl: NUM_THREADS must be at least 2");
   end
   if (TID_W < MIN_TID_W) begin : g_bad_width
      $error("cgmt_switch_ctrl: TID_W too narrow for NUM_THREADS");
   end

   sched_state_e           state_q, state_d;
   logic [TID_W-1:0]       active_q, active_d;
   logic                   perr_q;
   logic                   miss_ok;
   logic [NUM_THREADS-1:0] blocked;
   logic [NUM_THREADS-1:0] wake_vec;
   logic [NUM_THREADS-1:0] cand;
   logic                   pick_found;
   logic [TID_W-1:0]       pick_tid;

   assign miss_ok = miss_valid_i && (state_q == ST_RUN) && (miss_tid_i == active_q);

   cgmt_ready_tracker #(
      .NUM_THREADS (NUM_THREADS),
      .TID_W       (TID_W)
   ) u_tracker (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .block_en_i  (miss_ok),
      .block_tid_i (active_q),
      .wake_en_i   (ret_valid_i),
      .wake_tid_i  (ret_tid_i),
      .blocked_o   (blocked),
      .wake_vec_o  (wake_vec)
   );

   assign cand = ~blocked | wake_vec;

   cgmt_rr_picker #(
      .NUM_THREADS (NUM_THREADS),
      .TID_W       (TID_W)
   ) u_picker (
      .base_tid_i  (active_q),
      .cand_i      (cand),
      .found_o     (pick_found),
      .pick_o      (pick_tid)
   );

   always_comb begin
      state_d  = state_q;
      active_d = active_q;
      unique case (state_q)
         ST_RUN: begin
            if (miss_ok) state_d = ST_SWITCH;
         end
         ST_SWITCH: begin
            if (pick_found) begin
               state_d  = ST_RUN;
               active_d = pick_tid;
            end else begin
               state_d  = ST_IDLE;
            end
         end
         ST_IDLE: begin
            if (pick_found) begin
               state_d  = ST_RUN;
               active_d = pick_tid;
            end
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_RUN;
         active_q <= '0;
         perr_q   <= 1'b0;
      end else begin
         state_q  <= state_d;
         active_q <= active_d;
         perr_q   <= miss_valid_i && !miss_ok;
      end
   end

   assign active_tid_o  = active_q;
   assign issue_valid_o = (state_q == ST_RUN);
   assign flush_valid_o = (state_q == ST_SWITCH);
   assign flush_tid_o   = active_q;
   assign proto_err_o   = perr_q;

   AST_NO_PREEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_valid_o && !(miss_valid_i && miss_tid_i == active_tid_o))
      |=> (issue_valid_o && active_tid_o == $past(active_tid_o))); // R2

   AST_SWITCH_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_valid_o && miss_valid_i && miss_tid_i == active_tid_o)
      |=> (!issue_valid_o && flush_valid_o && flush_tid_o == $past(active_tid_o))); // R3

   AST_FLUSH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_valid_o |=> !flush_valid_o); // R3

   AST_NEVER_ISSUE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_valid_o |-> !blocked[active_tid_o]); // R5

   AST_WAKE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && ret_valid_i && blocked[ret_tid_i])
      |=> (issue_valid_o && active_tid_o == $past(ret_tid_i))); // R6

   AST_PROTO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (miss_valid_i && !(issue_valid_o && miss_tid_i == active_tid_o))
      |=> proto_err_o); // R8

endmodule

// File: tb/cgmt_switch_ctrl_tb.sv
`timescale 1ns/1ps
module cgmt_switch_ctrl_tb;

   localparam int NT = 4;
   localparam int TW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_valid = 1'b0;
   logic [TW-1:0] miss_tid = '0;
   logic          ret_valid = 1'b0;
   logic [TW-1:0] ret_tid = '0;
   logic [TW-1:0] active_tid;
   logic          issue_valid;
   logic          flush_valid;
   logic [TW-1:0] flush_tid;
   logic          proto_err;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   cgmt_switch_ctrl #(.NUM_THREADS(NT)) u_dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .miss_valid_i  (miss_valid),
      .miss_tid_i    (miss_tid),
      .ret_valid_i   (ret_valid),
      .ret_tid_i     (ret_tid),
      .active_tid_o  (active_tid),
      .issue_valid_o (issue_valid),
      .flush_valid_o (flush_valid),
      .flush_tid_o   (flush_tid),
      .proto_err_o   (proto_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic expect_state(input string req, input int exp_iv, input int exp_act,
                               input int exp_fl);
      check(int'(issue_valid) == exp_iv, req, "issue_valid", int'(issue_valid), exp_iv);
      if (exp_iv == 1)
         check(int'(active_tid) == exp_act, req, "active_tid", int'(active_tid), exp_act);
      check(int'(flush_valid) == exp_fl, req, "flush_valid", int'(flush_valid), exp_fl);
   endtask

   // Stall on the running thread; exp_next < 0 means nothing is ready.
   task automatic do_miss(input string req, input int tid, input int exp_next);
      @(negedge clk);
      miss_valid = 1'b1;
      miss_tid   = TW'(tid);
      @(negedge clk);
      miss_valid = 1'b0;
      expect_state("R3", 0, 0, 1);
      check(int'(flush_tid) == tid, "R3", "flush_tid", int'(flush_tid), tid);
      @(negedge clk);
      if (exp_next < 0) expect_state(req, 0, 0, 0);
      else              expect_state(req, 1, exp_next, 0);
   endtask

   task automatic do_return(input string req, input int tid, input int exp_iv,
                            input int exp_act);
      @(negedge clk);
      ret_valid = 1'b1;
      ret_tid   = TW'(tid);
      @(negedge clk);
      ret_valid = 1'b0;
      expect_state(req, exp_iv, exp_act, 0);
   endtask

   task automatic do_bad_miss(input int tid, input int exp_iv, input int exp_act);
      @(negedge clk);
      miss_valid = 1'b1;
      miss_tid   = TW'(tid);
      @(negedge clk);
      miss_valid = 1'b0;
      check(proto_err == 1'b1, "R8", "proto_err set", int'(proto_err), 1);
      expect_state("R8", exp_iv, exp_act, 0);
      @(negedge clk);
      check(proto_err == 1'b0, "R8", "proto_err one cycle", int'(proto_err), 0);
      expect_state("R8", exp_iv, exp_act, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      expect_state("R1", 1, 0, 0);
      check(int'(active_tid) == 0, "R1", "active_tid", int'(active_tid), 0);
      check(proto_err == 1'b0, "R1", "proto_err", int'(proto_err), 0);
   endtask

   task automatic t_hold(input int cycles, input int exp_act);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         expect_state("R2", 1, exp_act, 0);
      end
   endtask

   task automatic t_idle_hold(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         expect_state("R6", 0, 0, 0);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(20000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();                     // R1
      t_hold(4, 0);                  // R2
      do_return("R7", 0, 1, 0);      // R7: thread 0 not blocked
      t_hold(2, 0);                  // R7
      do_miss("R4", 0, 1);           // R3 R4: blocked {0}
      do_bad_miss(3, 1, 1);          // R8: not active
      do_miss("R4", 1, 2);           // blocked {0,1}
      do_return("R7", 3, 1, 2);      // R7: 3 is ready, no effect
      do_miss("R4", 2, 3);           // blocked {0,1,2}
      do_miss("R6", 3, -1);          // R6: all blocked
      t_idle_hold(3);                // R6
      do_bad_miss(1, 0, 0);          // R8: stall while not issuing
      do_return("R6", 2, 1, 2);      // R6: wake 2, blocked {0,1,3}
      do_return("R5", 3, 1, 2);      // blocked {0,1}
      do_return("R5", 0, 1, 2);      // blocked {1}
      do_miss("R4", 2, 3);           // R4: 3 not lowest-ready 0
      do_miss("R4", 3, 0);           // R4: wrap to 0, blocked {1,2,3}
      do_return("R5", 3, 1, 0);      // blocked {1,2}
      do_miss("R5", 0, 3);           // R5: skips blocked 1 and 2
      t_hold(3, 3);                  // R2
      finish_run();
   end

endmodule